// File: doc/BRIEF.md
# Tri-Level PWM Input Decoder

This block turns a digitised reading of a three-level PWM control pin into one of three drive commands: low, high or shutdown. Each reading arrives as an unsigned ADC code with a one-cycle valid strobe. The block keeps a registered two-bit command for a downstream gate sequencer, and it only acts on strobed readings.

A middle band of input levels asks for shutdown. The edges of that band depend on the side from which the input entered it. The block holds a side reference that records the last full excursion, either above the top of the band or below its bottom. When the reference is low, the band begins a little above the low rail. When it is high, the band begins a little below the high rail. A reading in the band becomes a shutdown command only after enough consecutive strobed readings have stayed in the band.

Before the holdoff expires, a pair of ordinary hysteresis thresholds moves the command between low and high. Once the block is in shutdown, it stays there until a reading leaves the widest band, either above the high exit or below the low exit.

Top module: `tlpwm_decoder`

## Requirements
- R1: Command encoding is 2'b00 low, 2'b01 high, 2'b10 shutdown, and 2'b11 never appears. A synchronous reset selects low and a low side reference.
- R2: A cycle with the valid strobe low changes neither the command, nor the side reference, nor the holdoff count, whatever the code.
- R3: With a low side reference, a reading is in the band when code > WIN_ENTER_RISE (default 92) and code <= WIN_EXIT_HIGH (default 183).
- R4: With a high side reference, a reading is in the band when code < WIN_ENTER_FALL (default 152) and code >= WIN_EXIT_LOW (default 59).
- R5: The command becomes shutdown on the clock edge that takes in the HOLD_TICKS-th consecutive in-band strobed reading (default 17), and not before.
- R6: A strobed reading outside the band restarts the holdoff count from zero.
- R7: In shutdown, readings from 59 to 183 inclusive keep shutdown. A reading above 183 gives high, and a reading below 59 gives low, on that same edge.
- R8: Outside shutdown, low changes to high when code > LVL_RISE (default 132), and high changes to low when code < LVL_FALL (default 101). Otherwise the command is kept.
- R9: The side reference becomes high on a strobed code above 183 and low on a strobed code below 59. A high command reached through R8 alone does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_code | input | CODE_W | ADC code of the PWM pin level |
| sample_valid | input | 1 | Strobe marking sample_code as a fresh reading |
| pwm_state | output | 2 | Registered command: 00 low, 01 high, 10 shutdown |

## Verification
A wrong side reference is not visible at the port straight away. It appears only when a reading lands between the two sets of band edges, for example code 160. Such a reading then reaches shutdown, or fails to, after a full holdoff run of 17 strobes. The scenarios therefore park on such codes for the whole holdoff. A holdoff count that is wrong or not cleared moves the shutdown edge by one or more strobes. Because of this, each holdoff scenario checks the command both on the strobe before expiry and on the strobe of expiry. A hysteresis fault shows on the very next strobe.

// File: rtl/tlpwm_pkg.sv
package tlpwm_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_SHDN = 2'b10
  } lvl_e;
endpackage

// File: rtl/tlpwm_compare.sv
module tlpwm_compare #(
  parameter int CODE_W         = 8,
  parameter int WIN_ENTER_RISE = 92,
  parameter int WIN_EXIT_HIGH  = 183,
  parameter int WIN_ENTER_FALL = 152,
  parameter int WIN_EXIT_LOW   = 59,
  parameter int LVL_RISE       = 132,
  parameter int LVL_FALL       = 101
) (
  input  logic [CODE_W-1:0] code,
  input  logic              side_hi,
  output logic              in_win,
  output logic              above_top,
  output logic              below_bot,
  output logic              lvl_up,
  output logic              lvl_dn
);
  localparam logic [CODE_W-1:0] ER = CODE_W'(WIN_ENTER_RISE);
  localparam logic [CODE_W-1:0] XH = CODE_W'(WIN_EXIT_HIGH);
  localparam logic [CODE_W-1:0] EF = CODE_W'(WIN_ENTER_FALL);
  localparam logic [CODE_W-1:0] XL = CODE_W'(WIN_EXIT_LOW);
  localparam logic [CODE_W-1:0] LR = CODE_W'(LVL_RISE);
  localparam logic [CODE_W-1:0] LF = CODE_W'(LVL_FALL);

  logic win_from_low, win_from_high;

  always_comb begin
    above_top     = code > XH;
    below_bot     = code < XL;
    win_from_low  = (code > ER) && !above_top;
    win_from_high = (code < EF) && !below_bot;
    in_win        = side_hi ? win_from_high : win_from_low;
    lvl_up        = code > LR;
    lvl_dn        = code < LF;
  end
endmodule

// File: rtl/tlpwm_holdoff.sv
module tlpwm_holdoff #(
  parameter int HOLD_TICKS = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic in_win,
  input  logic clear,
  output logic expire
);
  localparam int CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = valid && in_win && !clear && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (valid) begin
      if (!in_win || clear || expire) cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  win_break_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !in_win) |=> (cnt_q == '0));

  // R2
  count_idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(cnt_q));
endmodule

// File: rtl/tlpwm_level.sv
module tlpwm_level
  import tlpwm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic above_top,
  input  logic below_bot,
  input  logic lvl_up,
  input  logic lvl_dn,
  input  logic expire,
  output lvl_e state_q,
  output logic side_hi_q
);
  lvl_e state_d;
  logic side_d;

  always_comb begin
    state_d = state_q;
    side_d  = side_hi_q;
    if (valid) begin
      if (above_top)      side_d = 1'b1;
      else if (below_bot) side_d = 1'b0;
      case (state_q)
        LVL_SHDN: begin
          if (above_top)      state_d = LVL_HIGH;
          else if (below_bot) state_d = LVL_LOW;
        end
        LVL_HIGH: begin
          if (expire)      state_d = LVL_SHDN;
          else if (lvl_dn) state_d = LVL_LOW;
        end
        default: begin
          if (expire)      state_d = LVL_SHDN;
          else if (lvl_up) state_d = LVL_HIGH;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= LVL_LOW;
      side_hi_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      side_hi_q <= side_d;
    end
  end

  // R1
  enc_legal_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != 2'b11);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(state_q) && $stable(side_hi_q)));

  // R5
  shdn_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LVL_SHDN && $past(state_q) != LVL_SHDN) |-> $past(expire));

  // R7
  shdn_exit_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LVL_SHDN && valid && above_top) |=> (state_q == LVL_HIGH));

  // R8
  low_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LVL_LOW && valid && !expire && !lvl_up) |=> (state_q == LVL_LOW));
endmodule

// File: rtl/tlpwm_decoder.sv
module tlpwm_decoder
  import tlpwm_pkg::*;
#(
  parameter int CODE_W         = 8,
  parameter int WIN_ENTER_RISE = 92,
  parameter int WIN_EXIT_HIGH  = 183,
  parameter int WIN_ENTER_FALL = 152,
  parameter int WIN_EXIT_LOW   = 59,
  parameter int LVL_RISE       = 132,
  parameter int LVL_FALL       = 101,
  parameter int HOLD_TICKS     = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sample_code,
  input  logic              sample_valid,
  output logic [1:0]        pwm_state
);
  logic in_win, above_top, below_bot, lvl_up, lvl_dn, expire, side_hi;
  lvl_e state_q;

  tlpwm_compare #(
    .CODE_W(CODE_W), .WIN_ENTER_RISE(WIN_ENTER_RISE), .WIN_EXIT_HIGH(WIN_EXIT_HIGH),
    .WIN_ENTER_FALL(WIN_ENTER_FALL), .WIN_EXIT_LOW(WIN_EXIT_LOW),
    .LVL_RISE(LVL_RISE), .LVL_FALL(LVL_FALL)
  ) u_cmp (
    .code(sample_code), .side_hi(side_hi), .in_win(in_win), .above_top(above_top),
    .below_bot(below_bot), .lvl_up(lvl_up), .lvl_dn(lvl_dn)
  );

  tlpwm_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(rst), .valid(sample_valid), .in_win(in_win),
    .clear(state_q == LVL_SHDN), .expire(expire)
  );

  tlpwm_level u_lvl (
    .clk(clk), .rst(rst), .valid(sample_valid), .above_top(above_top),
    .below_bot(below_bot), .lvl_up(lvl_up), .lvl_dn(lvl_dn), .expire(expire),
    .state_q(state_q), .side_hi_q(side_hi)
  );

  assign pwm_state = state_q;
endmodule

// File: tb/tlpwm_decoder_test.sv
module tlpwm_decoder_test;
  localparam int HOLD = 17;
  localparam logic [1:0] S_LOW = 2'b00, S_HIGH = 2'b01, S_SHDN = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] code = '0;
  logic valid = 1'b0;
  logic [1:0] pwm_state;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  tlpwm_decoder uut (.clk(clk), .rst(rst), .sample_code(code),
                     .sample_valid(valid), .pwm_state(pwm_state));

  task automatic check(input logic [1:0] exp, input string tag);
    checks++;
    if (pwm_state !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, pwm_state, exp);
    end
  endtask

  task automatic put(input logic [7:0] c);
    @(negedge clk); code = c; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic put_n(input logic [7:0] c, input int n);
    for (int i = 0; i < n; i++) put(c);
  endtask

  task automatic go_low;  put(8'd0);   endtask
  task automatic go_high; put(8'd255); endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(S_LOW, "R1 reset state");
  endtask

  task automatic t_idle;
    go_low;
    @(negedge clk); code = 8'd255;
    repeat (6) @(negedge clk);
    check(S_LOW, "R2 unstrobed code ignored");
    put_n(8'd100, HOLD - 1);
    code = 8'd0;
    repeat (8) @(negedge clk);
    check(S_LOW, "R2 count paused");
    put(8'd100);
    check(S_SHDN, "R2 count kept across idle");
  endtask

  task automatic t_rise_window;
    go_low;
    put_n(8'd92, HOLD + 3);
    check(S_LOW, "R3 code 92 not in band");
    put_n(8'd93, HOLD - 1);
    check(S_LOW, "R5 one short of holdoff");
    put(8'd93);
    check(S_SHDN, "R5 holdoff expiry");
    go_low;
    put(8'd183);
    check(S_HIGH, "R8 rise above 132");
    put_n(8'd183, HOLD - 1);
    check(S_SHDN, "R3 code 183 in band");
  endtask

  task automatic t_fall_window;
    go_high;
    put_n(8'd152, HOLD + 3);
    check(S_HIGH, "R4 code 152 not in band");
    put(8'd59);
    check(S_LOW, "R8 fall below 101");
    put_n(8'd59, HOLD - 1);
    check(S_SHDN, "R4 code 59 in band");
    put(8'd58);
    check(S_LOW, "R7 exit below 59");
  endtask

  task automatic t_break;
    go_low;
    put_n(8'd100, HOLD - 1);
    put(8'd91);
    check(S_LOW, "R6 out-of-band keeps low");
    put_n(8'd100, HOLD - 1);
    check(S_LOW, "R6 count restarted");
    put(8'd100);
    check(S_SHDN, "R6 full run after restart");
  endtask

  task automatic t_shdn_exit;
    go_low;
    put_n(8'd100, HOLD);
    put(8'd59);
    check(S_SHDN, "R7 stays at 59");
    put(8'd183);
    check(S_SHDN, "R7 stays at 183");
    put(8'd184);
    check(S_HIGH, "R7 exit above 183");
    put_n(8'd151, HOLD);
    check(S_SHDN, "R9 side high after exit");
  endtask

  task automatic t_levels;
    go_low;
    put(8'd132);
    check(S_LOW, "R8 132 not above rise");
    put(8'd133);
    check(S_HIGH, "R8 133 rises");
    put(8'd101);
    check(S_HIGH, "R8 101 keeps high");
    put(8'd100);
    check(S_LOW, "R8 100 falls");
  endtask

  task automatic t_side;
    go_low;
    put(8'd140);
    check(S_HIGH, "R8 140 from low");
    put_n(8'd160, HOLD);
    check(S_SHDN, "R9 side stays low via hysteresis");
    go_high;
    put_n(8'd160, HOLD + 2);
    check(S_HIGH, "R9 side high excludes 160");
  endtask

  task automatic t_reset_mid;
    go_low;
    put_n(8'd120, HOLD);
    check(S_SHDN, "R5 shutdown before reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(S_LOW, "R1 reset from shutdown");
  endtask

  initial begin
    t_reset;
    t_idle;
    t_rise_window;
    t_fall_window;
    t_break;
    t_shdn_exit;
    t_levels;
    t_side;
    t_reset_mid;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule